// File: doc/BRIEF.md
# Hardware Cursor Overlay Generator

This block paints a 64x64 pointer image on top of a scanned-out pixel stream. Each cursor pixel is a 2-bit code. The code picks one of two programmable colours, lets the underlying pixel through, or inverts it. The display timing source supplies a frame pulse, a line pulse in horizontal blanking, a data-enable flag and the underlying pixel. The block returns the mixed pixel one clock later.

For every display line that the cursor covers, the block reads one cursor row from display memory during horizontal blanking. A row is two 64-bit words, and the read port has a fixed one-cycle latency. A small register port sets the enable, the colours, the bitmap start address, the screen position and two preset counts. The presets drop leading rows and columns of the image, so the cursor can be clipped at the top and left screen edges without using a negative position.

The timing source must leave at least three blanking cycles between a line pulse and the first data-enable cycle of that line. It must never assert the frame pulse and the line pulse in the same cycle.

Top module: `hw_cursor_overlay`

## Requirements
- R1: While reset is held and right after it, `out_valid` and `mem_rd_en` are 0.
- R2: When the enable bit (bit 7 of the control register, address 0) is clear, every active pixel leaves unchanged and no memory read is made.
- R3: Code 0 outputs colour 0 (address 1), code 1 outputs colour 1 (address 2), code 2 passes the underlying pixel, and code 3 outputs its bitwise complement.
- R4: The code for cursor column c sits at bits 2c+1:2c of the 128-bit row formed by the word at the lower address (low half) and the word at the next address (high half).
- R5: Cursor row r is read as two consecutive reads, at start address (address 3, counted in 64-bit words) plus 2r and then plus 2r+1.
- R6: The position register (address 4) holds y in bits 31:16 and x in bits 15:0. The first shown cursor pixel lands on that screen coordinate, counted from the first active pixel of the frame's first line.
- R7: The preset register (address 5) holds a row skip in bits 31:16 and a column skip in bits 15:0. Screen pixel (X, Y) shows cursor column X-x+skip_x and cursor row Y-y+skip_y when both are below 64 and X>=x, Y>=y.
- R8: Writes to start address, position and preset take effect at the next frame pulse. The frame in progress keeps the old values.
- R9: Enable and colour writes apply from the next pixel onward. Colours are full pixel-width values used unmodified.
- R10: `out_valid` and `pix_out` follow `de` and `pix_in` with one cycle of latency.
- R11: Cursor parts that fall past the right or bottom edge of the active area are not drawn, and they do not wrap onto other pixels.
- R12: Lines that no cursor row covers cause no memory reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| line_start | input | 1 | One-cycle pulse in blanking before each active line |
| de | input | 1 | Active-video data enable |
| pix_in | input | PIX_W | Underlying pixel |
| mem_rd_en | output | 1 | Cursor bitmap read request |
| mem_rd_addr | output | MEM_AW | Read address in 64-bit words |
| mem_rd_data | input | 64 | Read data, valid the cycle after the request |
| pix_out | output | PIX_W | Mixed pixel |
| out_valid | output | 1 | Mixed pixel valid |

## Verification
The bench moves the cursor to the right and bottom edges. A design that wraps columns or rows would paint cursor codes onto pixels beyond the clip. The bench clips the top-left through presets. Getting the skip wrong shifts the whole image and makes it read the wrong memory row. Position is rewritten in the middle of a frame. A design that does not defer it would draw a torn cursor on the remaining lines. A colour is also rewritten mid-frame, and a design that deferred it would keep the old colour. A disabled cursor must still pass every pixel through untouched and make no reads.

// File: rtl/hwc_pkg.sv
package hwc_pkg;
  localparam int CUR_DIM  = 64;
  localparam int ROW_BITS = 2 * CUR_DIM;

  localparam logic [2:0] RA_CTRL   = 3'd0;
  localparam logic [2:0] RA_COLOR0 = 3'd1;
  localparam logic [2:0] RA_COLOR1 = 3'd2;
  localparam logic [2:0] RA_BASE   = 3'd3;
  localparam logic [2:0] RA_POS    = 3'd4;
  localparam logic [2:0] RA_PRESET = 3'd5;

  localparam int EN_BIT = 7;

  typedef enum logic [1:0] {
    CODE_C0   = 2'd0,
    CODE_C1   = 2'd1,
    CODE_PASS = 2'd2,
    CODE_INV  = 2'd3
  } cur_code_e;

  typedef enum logic [1:0] {
    F_IDLE = 2'd0,
    F_REQ0 = 2'd1,
    F_REQ1 = 2'd2,
    F_CAP1 = 2'd3
  } fetch_st_e;
endpackage

// File: rtl/hwc_regs.sv
module hwc_regs
  import hwc_pkg::*;
#(
  parameter int PIX_W   = 24,
  parameter int MEM_AW  = 16,
  parameter int COORD_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [2:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  input  logic               frame_start,
  output logic               cur_en,
  output logic [PIX_W-1:0]   color0,
  output logic [PIX_W-1:0]   color1,
  output logic [MEM_AW-1:0]  base_sh,
  output logic [COORD_W-1:0] pos_x_sh,
  output logic [COORD_W-1:0] pos_y_sh,
  output logic [COORD_W-1:0] pre_x_sh,
  output logic [COORD_W-1:0] pre_y_sh
);
  logic               en_q;
  logic [PIX_W-1:0]   c0_q, c1_q;
  logic [MEM_AW-1:0]  base_q, base_s_q;
  logic [COORD_W-1:0] px_q, py_q, rx_q, ry_q;
  logic [COORD_W-1:0] px_s_q, py_s_q, rx_s_q, ry_s_q;

  logic we_ctrl, we_c0, we_c1, we_base, we_pos, we_pre;
  logic unused_wdata;

  always_comb begin
    we_ctrl = reg_we && (reg_addr == RA_CTRL);
    we_c0   = reg_we && (reg_addr == RA_COLOR0);
    we_c1   = reg_we && (reg_addr == RA_COLOR1);
    we_base = reg_we && (reg_addr == RA_BASE);
    we_pos  = reg_we && (reg_addr == RA_POS);
    we_pre  = reg_we && (reg_addr == RA_PRESET);
  end

  assign unused_wdata = ^reg_wdata;

  // Staged (software-visible) registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      c0_q   <= '0;
      c1_q   <= '0;
      base_q <= '0;
      px_q   <= '0;
      py_q   <= '0;
      rx_q   <= '0;
      ry_q   <= '0;
    end else begin
      if (we_ctrl) en_q   <= reg_wdata[EN_BIT];
      if (we_c0)   c0_q   <= reg_wdata[PIX_W-1:0];
      if (we_c1)   c1_q   <= reg_wdata[PIX_W-1:0];
      if (we_base) base_q <= reg_wdata[MEM_AW-1:0];
      if (we_pos) begin
        px_q <= reg_wdata[COORD_W-1:0];
        py_q <= reg_wdata[16+COORD_W-1:16];
      end
      if (we_pre) begin
        rx_q <= reg_wdata[COORD_W-1:0];
        ry_q <= reg_wdata[16+COORD_W-1:16];
      end
    end
  end

  // Frame-synchronous shadow copies
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_s_q <= '0;
      px_s_q   <= '0;
      py_s_q   <= '0;
      rx_s_q   <= '0;
      ry_s_q   <= '0;
    end else if (frame_start) begin
      base_s_q <= base_q;
      px_s_q   <= px_q;
      py_s_q   <= py_q;
      rx_s_q   <= rx_q;
      ry_s_q   <= ry_q;
    end
  end

  assign cur_en   = en_q;
  assign color0   = c0_q;
  assign color1   = c1_q;
  assign base_sh  = base_s_q;
  assign pos_x_sh = px_s_q;
  assign pos_y_sh = py_s_q;
  assign pre_x_sh = rx_s_q;
  assign pre_y_sh = ry_s_q;

  assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(pos_x_sh) && $stable(pos_y_sh) && $stable(base_sh)
                      && $stable(pre_x_sh) && $stable(pre_y_sh)));

  assert_color_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    we_c1 |=> color1 == $past(reg_wdata[PIX_W-1:0]));
endmodule

// File: rtl/hwc_fetch.sv
module hwc_fetch
  import hwc_pkg::*;
#(
  parameter int MEM_AW  = 16,
  parameter int COORD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_start,
  input  logic                line_start,
  input  logic                cur_en,
  input  logic [MEM_AW-1:0]   base_sh,
  input  logic [COORD_W-1:0]  pos_y_sh,
  input  logic [COORD_W-1:0]  pre_y_sh,
  output logic                mem_rd_en,
  output logic [MEM_AW-1:0]   mem_rd_addr,
  input  logic [63:0]         mem_rd_data,
  output logic [ROW_BITS-1:0] row_bits,
  output logic                row_valid
);
  localparam int RW = $clog2(CUR_DIM);
  localparam int SW = COORD_W + 2;

  fetch_st_e           st_q, st_d;
  logic [COORD_W-1:0]  ny_q, ny_d;
  logic [MEM_AW-1:0]   addr_q, addr_d;
  logic [ROW_BITS-1:0] row_q, row_d;
  logic                vld_q, vld_d;

  logic [SW-1:0]       row_sum;
  logic                row_hit;
  logic [MEM_AW-1:0]   row_off;

  always_comb begin
    row_sum = {2'b00, ny_q} + {2'b00, pre_y_sh} - {2'b00, pos_y_sh};
    row_hit = cur_en && (ny_q >= pos_y_sh) && (row_sum < SW'(CUR_DIM));
    row_off = MEM_AW'({row_sum[RW-1:0], 1'b0});
  end

  always_comb begin
    st_d   = st_q;
    ny_d   = ny_q;
    addr_d = addr_q;
    row_d  = row_q;
    vld_d  = vld_q;
    if (frame_start) ny_d = '0;
    case (st_q)
      F_IDLE: begin
        if (line_start) begin
          ny_d  = ny_q + 1'b1;
          vld_d = 1'b0;
          if (row_hit) begin
            addr_d = base_sh + row_off;
            st_d   = F_REQ0;
          end
        end
      end
      F_REQ0: begin
        addr_d = addr_q + 1'b1;
        st_d   = F_REQ1;
      end
      F_REQ1: begin
        row_d[63:0] = mem_rd_data;
        st_d        = F_CAP1;
      end
      default: begin
        row_d[ROW_BITS-1:64] = mem_rd_data;
        vld_d                = 1'b1;
        st_d                 = F_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= F_IDLE;
      ny_q   <= '0;
      addr_q <= '0;
      row_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      ny_q   <= ny_d;
      addr_q <= addr_d;
      row_q  <= row_d;
      vld_q  <= vld_d;
    end
  end

  assign mem_rd_en   = (st_q == F_REQ0) || (st_q == F_REQ1);
  assign mem_rd_addr = addr_q;
  assign row_bits    = row_q;
  assign row_valid   = vld_q;

  assert_read_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && !$past(mem_rd_en)) |=> (mem_rd_en && mem_rd_addr == $past(mem_rd_addr) + 1'b1));

  assert_line_clears_row_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && st_q == F_IDLE) |=> !row_valid);

  assert_no_read_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && !cur_en && st_q == F_IDLE) |=> !mem_rd_en);
endmodule

// File: rtl/hwc_mixer.sv
module hwc_mixer
  import hwc_pkg::*;
#(
  parameter int PIX_W   = 24,
  parameter int COORD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                line_start,
  input  logic                de,
  input  logic [PIX_W-1:0]    pix_in,
  input  logic                cur_en,
  input  logic                row_valid,
  input  logic [ROW_BITS-1:0] row_bits,
  input  logic [PIX_W-1:0]    color0,
  input  logic [PIX_W-1:0]    color1,
  input  logic [COORD_W-1:0]  pos_x_sh,
  input  logic [COORD_W-1:0]  pre_x_sh,
  output logic [PIX_W-1:0]    pix_out,
  output logic                out_valid
);
  localparam int CW = $clog2(CUR_DIM);
  localparam int SW = COORD_W + 2;

  logic [COORD_W-1:0] x_q, x_d;
  logic [PIX_W-1:0]   pix_q, pix_d;
  logic               ov_q;

  logic [SW-1:0]      col_sum;
  logic               in_cur;
  logic [CW:0]        bit_idx;
  cur_code_e          code;

  always_comb begin
    col_sum = {2'b00, x_q} + {2'b00, pre_x_sh} - {2'b00, pos_x_sh};
    in_cur  = cur_en && row_valid && (x_q >= pos_x_sh) && (col_sum < SW'(CUR_DIM));
    bit_idx = {col_sum[CW-1:0], 1'b0};
    code    = cur_code_e'(row_bits[bit_idx +: 2]);
  end

  always_comb begin
    pix_d = pix_in;
    if (in_cur) begin
      case (code)
        CODE_C0:   pix_d = color0;
        CODE_C1:   pix_d = color1;
        CODE_PASS: pix_d = pix_in;
        default:   pix_d = ~pix_in;
      endcase
    end
    x_d = x_q;
    if (line_start)  x_d = '0;
    else if (de)     x_d = x_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q   <= '0;
      pix_q <= '0;
      ov_q  <= 1'b0;
    end else begin
      x_q  <= x_d;
      ov_q <= de;
      if (de) pix_q <= pix_d;
    end
  end

  assign pix_out   = pix_q;
  assign out_valid = ov_q;

  assert_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (de && !cur_en) |=> (pix_out == $past(pix_in)));

  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    de |=> out_valid);

  assert_idle_invalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !de |=> !out_valid);
endmodule

// File: rtl/hw_cursor_overlay.sv
module hw_cursor_overlay
  import hwc_pkg::*;
#(
  parameter int PIX_W   = 24,
  parameter int MEM_AW  = 16,
  parameter int COORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              frame_start,
  input  logic              line_start,
  input  logic              de,
  input  logic [PIX_W-1:0]  pix_in,
  output logic              mem_rd_en,
  output logic [MEM_AW-1:0] mem_rd_addr,
  input  logic [63:0]       mem_rd_data,
  output logic [PIX_W-1:0]  pix_out,
  output logic              out_valid
);
  logic rst_s1_q, rst_s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  logic                cur_en;
  logic [PIX_W-1:0]    color0, color1;
  logic [MEM_AW-1:0]   base_sh;
  logic [COORD_W-1:0]  pos_x_sh, pos_y_sh, pre_x_sh, pre_y_sh;
  logic [ROW_BITS-1:0] row_bits;
  logic                row_valid;

  hwc_regs #(.PIX_W(PIX_W), .MEM_AW(MEM_AW), .COORD_W(COORD_W)) u_regs (
    .clk(clk), .rst_n(rst_s2_q), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .frame_start(frame_start), .cur_en(cur_en),
    .color0(color0), .color1(color1), .base_sh(base_sh),
    .pos_x_sh(pos_x_sh), .pos_y_sh(pos_y_sh),
    .pre_x_sh(pre_x_sh), .pre_y_sh(pre_y_sh)
  );

  hwc_fetch #(.MEM_AW(MEM_AW), .COORD_W(COORD_W)) u_fetch (
    .clk(clk), .rst_n(rst_s2_q), .frame_start(frame_start),
    .line_start(line_start), .cur_en(cur_en), .base_sh(base_sh),
    .pos_y_sh(pos_y_sh), .pre_y_sh(pre_y_sh), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .row_bits(row_bits), .row_valid(row_valid)
  );

  hwc_mixer #(.PIX_W(PIX_W), .COORD_W(COORD_W)) u_mixer (
    .clk(clk), .rst_n(rst_s2_q), .line_start(line_start), .de(de),
    .pix_in(pix_in), .cur_en(cur_en), .row_valid(row_valid),
    .row_bits(row_bits), .color0(color0), .color1(color1),
    .pos_x_sh(pos_x_sh), .pre_x_sh(pre_x_sh),
    .pix_out(pix_out), .out_valid(out_valid)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_s2_q |=> (!mem_rd_en && !out_valid));
endmodule

// File: tb/hw_cursor_overlay_bench.sv
module hw_cursor_overlay_bench;
  localparam int PW = 24;
  localparam int AW = 16;
  localparam int HACT = 80;
  localparam int VLINES = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic          frame_start = 1'b0, line_start = 1'b0, de = 1'b0;
  logic [PW-1:0] pix_in = '0;
  logic          mem_rd_en;
  logic [AW-1:0] mem_rd_addr;
  logic [63:0]   mem_rd_data = '0;
  logic [PW-1:0] pix_out;
  logic          out_valid;

  always #5 clk = ~clk;

  hw_cursor_overlay #(.PIX_W(PW), .MEM_AW(AW), .COORD_W(16)) u_hw_cursor_overlay (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .frame_start(frame_start), .line_start(line_start),
    .de(de), .pix_in(pix_in), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .pix_out(pix_out), .out_valid(out_valid)
  );

  // Bitmap memory, one-cycle read latency
  logic [63:0] mem [256];
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[7:0]];

  int    n_tests = 0, n_fail = 0;
  string tag = "R1";

  // Reference model state
  bit          m_en;
  logic [PW-1:0] m_c0, m_c1;
  int          st_base, st_px, st_py, st_rx, st_ry;
  int          sh_base, sh_px, sh_py, sh_rx, sh_ry;
  int          m_ny, m_x;
  bit          m_rv;
  logic [127:0] m_row;
  int          exp_addr[$];
  bit          exp_v = 1'b0;
  logic [PW-1:0] exp_p;
  int          frame_no = 0;

  typedef struct { logic [2:0] a; logic [31:0] d; } wr_t;
  wr_t pend[$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [PW-1:0] model_pix(input logic [PW-1:0] p);
    int col, row_ok;
    logic [1:0] c;
    row_ok = m_en && m_rv;
    col = m_x - sh_px + sh_rx;
    if (!row_ok || m_x < sh_px || col >= 64) return p;
    c = m_row[2*col +: 2];
    case (c)
      2'd0: return m_c0;
      2'd1: return m_c1;
      2'd2: return p;
      default: return ~p;
    endcase
  endfunction

  task automatic apply_write(input logic [2:0] a, input logic [31:0] d);
    case (a)
      3'd0: m_en = d[7];
      3'd1: m_c0 = d[PW-1:0];
      3'd2: m_c1 = d[PW-1:0];
      3'd3: st_base = int'(d[15:0]);
      3'd4: begin st_px = int'(d[15:0]); st_py = int'(d[31:16]); end
      3'd5: begin st_rx = int'(d[15:0]); st_ry = int'(d[31:16]); end
      default: ;
    endcase
  endtask

  task automatic step(input bit vs, input bit ls, input bit dv, input logic [PW-1:0] px,
                      input bit we, input logic [2:0] a, input logic [31:0] d);
    int row;
    @(negedge clk);
    // Check outputs of the previous cycle's inputs (R10 latency)
    chk(out_valid == exp_v, {"R10 valid ", tag}, 64'(out_valid), 64'(exp_v));
    if (exp_v)
      chk(pix_out == exp_p, {"R3 R4 pixel ", tag}, 64'(pix_out), 64'(exp_p));
    if (mem_rd_en) begin
      if (exp_addr.size() == 0)
        chk(1'b0, {"R12 unexpected read ", tag}, 64'(mem_rd_addr), 64'hFFFF);
      else begin
        int ea;
        ea = exp_addr.pop_front();
        chk(int'(mem_rd_addr) == ea, {"R5 read address ", tag}, 64'(mem_rd_addr), 64'(ea));
      end
    end
    // Drive
    frame_start = vs; line_start = ls; de = dv; pix_in = px;
    reg_we = we; reg_addr = a; reg_wdata = d;
    // Model
    exp_v = dv;
    if (dv) begin exp_p = model_pix(px); m_x++; end
    if (ls) begin
      m_x = 0;
      row = m_ny - sh_py + sh_ry;
      if (m_en && m_ny >= sh_py && row < 64) begin
        exp_addr.push_back(sh_base + 2*row);
        exp_addr.push_back(sh_base + 2*row + 1);
        m_row = {mem[(sh_base + 2*row + 1) & 255], mem[(sh_base + 2*row) & 255]};
        m_rv = 1'b1;
      end else m_rv = 1'b0;
      m_ny++;
    end
    if (vs) begin
      sh_base = st_base; sh_px = st_px; sh_py = st_py; sh_rx = st_rx; sh_ry = st_ry;
      m_ny = 0;
    end
    if (we) apply_write(a, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, '0, 0, 3'd0, 32'd0);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    step(0, 0, 0, '0, 1, a, d);
  endtask

  task automatic frame(input string t, input int wline);
    tag = t;
    frame_no++;
    step(1, 0, 0, '0, 0, 3'd0, 32'd0);
    idle(2);
    for (int y = 0; y < VLINES; y++) begin
      step(0, 1, 0, '0, 0, 3'd0, 32'd0);
      for (int b = 0; b < 4; b++) begin
        if (y == wline && pend.size() > 0) begin
          wr_t w;
          w = pend.pop_front();
          step(0, 0, 0, '0, 1, w.a, w.d);
        end else step(0, 0, 0, '0, 0, 3'd0, 32'd0);
      end
      for (int x = 0; x < HACT; x++)
        step(0, 0, 1, PW'((y * 37 + x * 11 + frame_no * 91) ^ (x << 12)), 0, 3'd0, 32'd0);
      idle(2);
    end
    idle(3);
    chk(exp_addr.size() == 0, {"R5 R12 read count ", t}, 64'(exp_addr.size()), 64'd0);
    exp_addr.delete();
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++)
      mem[i] = {32'(i) * 32'h9E3779B9 ^ 32'h5A3C0F96, 32'(i + 7) * 32'h85EBCA6B ^ 32'hC3A5E10F};
    m_en = 0; m_c0 = '0; m_c1 = '0;
    st_base = 0; st_px = 0; st_py = 0; st_rx = 0; st_ry = 0;
    sh_base = 0; sh_px = 0; sh_py = 0; sh_rx = 0; sh_ry = 0;
    m_ny = 0; m_x = 0; m_rv = 0; m_row = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(out_valid == 1'b0, "R1 out_valid in reset", 64'(out_valid), 64'd0);
    chk(mem_rd_en == 1'b0, "R1 mem_rd_en in reset", 64'(mem_rd_en), 64'd0);
    rst_n = 1'b1;
    idle(5);
    chk(out_valid == 1'b0 && mem_rd_en == 1'b0, "R1 quiet after reset", 64'({out_valid, mem_rd_en}), 64'd0);

    // Setup, cursor disabled: R2 pass-through, no reads
    wr(3'd1, 32'h00123456);
    wr(3'd2, 32'h00ABCDEF);
    wr(3'd3, 32'h0000_0010);
    wr(3'd4, {16'd2, 16'd10});
    wr(3'd5, 32'd0);
    idle(2);
    frame("R2 disabled", -1);

    // Enable; R6 placement. Mid-frame: colour (R9 immediate), position (R8 deferred)
    wr(3'd0, 32'h0000_0080);
    idle(2);
    pend.push_back('{3'd1, 32'h0000FF00});
    pend.push_back('{3'd4, {16'd0, 16'd30}});
    frame("R6 R9 R8", 6);
    frame("R8 new position", -1);

    // Top/left clipping by presets, new base
    wr(3'd4, 32'd0);
    wr(3'd5, {16'd20, 16'd5});
    wr(3'd3, 32'h0000_0020);
    idle(2);
    frame("R7 presets", -1);

    // Right and bottom edges
    wr(3'd5, 32'd0);
    wr(3'd4, {16'd8, 16'd50});
    idle(2);
    frame("R11 edges", -1);

    // Disable in mid frame
    pend.push_back('{3'd0, 32'h0});
    frame("R2 R9 disable", 4);

    idle(3);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule